// File: doc/BRIEF.md
# Multi-Function Register Logic Cell

This block is one configurable logic cell. It receives four sum-of-products terms, named A, B, C and D, from a surrounding logic array, together with a small set of global controls. Each sum term is given a role by static configuration inputs. A can be register data or a plain combinational path. B can be the K input, an asynchronous preset, or a combinational path. C can be the cell clock, an asynchronous reset, or a combinational path. D can be the cell clock, an output enable, or a buried feedback node. The cell holds one state bit. That bit acts as a D, T or JK flip-flop, and a global register-type line can switch it at run time from D to T, or from D to JK. With this switching, a group of cells can load a value in D mode and then count in T mode.

The cell clock is detected on the fabric clock `clk`. The selected clock source is the C term if C has the clock role, otherwise the D term if D has the clock role, otherwise the global clock level `gclk_lvl`. That source is XORed with a per-cell inversion bit. An active edge is a 0 to 1 change of the result between two consecutive fabric cycles. The state bit takes its new value at the fabric edge where the new level is first sampled.

Preset and reset are level-sensitive. They take effect at every fabric edge, whether or not a cell-clock edge is present.

There are three outputs:
- `io_out` goes toward an I/O cell and comes with `io_oe`.
- `fb_out` goes back into the array.
- `bur_out` is the buried D path.

Top module: `mfc_cell`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises with no preset active, the state bit is 0, so any output routed to it reads 0.
- R2: With the effective type D (code 0) and A in the data role (`cfg_a_role` = 0), an active cell-clock edge loads A into the state bit.
- R3: With the effective type T (code 1), an active edge inverts the state bit when the data input is 1 and leaves it unchanged when it is 0.
- R4: With the effective type JK (code 2), J taken from A and K taken from B (`cfg_b_role` = 1): J/K = 1/1 inverts the bit, 0/0 holds it, 1/0 sets it and 0/1 clears it.
- R5: The clock source is C when `cfg_c_role` = 1, else D when `cfg_d_role` = 1, else `gclk_lvl`. It is XORed with `cfg_clk_inv`, and only a 0 to 1 change of that result updates the bit. Without such a change the bit holds.
- R6: A reset clears the bit at the next fabric edge. A reset is either C high with `cfg_c_role` = 2, or `g_reset` high. It overrides both preset and clock.
- R7: A preset sets the bit at the next fabric edge when no reset is active. A preset is either B high with `cfg_b_role` = 2, or `g_preset` high. It overrides the clock.
- R8: When `cfg_rt_en` = 1 and `g_rtype` = 1, the cell runs as T (`cfg_rt_alt` = 0) or JK (`cfg_rt_alt` = 1) regardless of `cfg_type`. When `cfg_rt_en` = 0, `g_rtype` has no effect. A type code of 3 acts as D.
- R9: `io_out` and `fb_out` each select, independently, by their 2-bit select: 0 = state bit, 1 = A, 2 = B, 3 = C.
- R10: `io_oe` equals D when `cfg_d_role` = 2 and is 1 otherwise. `bur_out` equals D when `cfg_d_role` = 0 and is 0 otherwise.
- R11: When A is in the combinational role (`cfg_a_role` = 1), the data/J input of the state bit is 0. When B is not in the K role, K is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock at which all cell edges are sampled |
| rst_n | input | 1 | Active-low power-up clear |
| sum_a | input | 1 | Sum term A |
| sum_b | input | 1 | Sum term B |
| sum_c | input | 1 | Sum term C |
| sum_d | input | 1 | Sum term D |
| gclk_lvl | input | 1 | Global system clock level |
| g_preset | input | 1 | Global preset |
| g_reset | input | 1 | Global reset |
| g_rtype | input | 1 | Global register-type switch |
| cfg_a_role | input | 1 | A role: 0 data, 1 combinational |
| cfg_b_role | input | 2 | B role: 0 combinational, 1 K, 2 preset |
| cfg_c_role | input | 2 | C role: 0 combinational, 1 clock, 2 reset |
| cfg_d_role | input | 2 | D role: 0 feedback, 1 clock, 2 output enable |
| cfg_type | input | 2 | Base type: 0 D, 1 T, 2 JK |
| cfg_rt_en | input | 1 | Cell follows `g_rtype` |
| cfg_rt_alt | input | 1 | Switched type: 0 T, 1 JK |
| cfg_clk_inv | input | 1 | Invert the clock source |
| cfg_io_sel | input | 2 | Source select for `io_out` |
| cfg_fb_sel | input | 2 | Source select for `fb_out` |
| io_out | output | 1 | Output toward the I/O cell |
| io_oe | output | 1 | Output enable toward the I/O cell |
| fb_out | output | 1 | Output back into the array |
| bur_out | output | 1 | Buried D path |

## Verification
The hardest situation to reach is a run-time type switch on a working group of cells. Here the same edge sequence must load under D and then count under T, and the data terms are themselves functions of the cells' own outputs. The bench builds a 4-bit loadable counter from four cells sharing `g_rtype`. It loads a value near the wrap point and checks every count across the wrap. Overlapping preset, reset and clock events come from directed sequences. A seeded random phase then mixes role, polarity and type settings against a bench-side model, so that combinations of clock source and control roles occur that the directed cases do not list.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  localparam int MFC_ROLE_W = 2;
  localparam int MFC_SEL_W  = 2;
  localparam int MFC_NROUTE = 2;

  typedef enum logic [1:0] {
    RT_D  = 2'd0,
    RT_T  = 2'd1,
    RT_JK = 2'd2
  } mfc_rtype_e;

  localparam logic A_DATA = 1'b0;
  localparam logic [MFC_ROLE_W-1:0] B_K      = 2'd1;
  localparam logic [MFC_ROLE_W-1:0] B_PRESET = 2'd2;
  localparam logic [MFC_ROLE_W-1:0] C_CLK    = 2'd1;
  localparam logic [MFC_ROLE_W-1:0] C_RESET  = 2'd2;
  localparam logic [MFC_ROLE_W-1:0] D_FB     = 2'd0;
  localparam logic [MFC_ROLE_W-1:0] D_CLK    = 2'd1;
  localparam logic [MFC_ROLE_W-1:0] D_OE     = 2'd2;

  localparam logic [MFC_SEL_W-1:0] SEL_Q = 2'd0;
  localparam logic [MFC_SEL_W-1:0] SEL_A = 2'd1;
  localparam logic [MFC_SEL_W-1:0] SEL_B = 2'd2;
  localparam logic [MFC_SEL_W-1:0] SEL_C = 2'd3;

  // Effective register type after the global switch is applied.
  function automatic mfc_rtype_e mfc_eff_type(input logic [1:0] base,
                                              input logic rt_en,
                                              input logic rt_alt,
                                              input logic g_rtype);
    mfc_rtype_e t;
    if (rt_en && g_rtype) begin
      t = rt_alt ? RT_JK : RT_T;
    end else begin
      case (base)
        2'd1:    t = RT_T;
        2'd2:    t = RT_JK;
        default: t = RT_D;
      endcase
    end
    return t;
  endfunction

  // Next value of the state bit on an active cell-clock edge.
  function automatic logic mfc_next_q(input mfc_rtype_e t, input logic q,
                                      input logic j, input logic k);
    logic n;
    case (t)
      RT_T:    n = q ^ j;
      RT_JK:   n = (j & ~q) | (~k & q);
      default: n = j;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mfc_clk_edge.sv
module mfc_clk_edge
  import mfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic c_is_clk,
  input  logic d_is_clk,
  input  logic sum_c,
  input  logic sum_d,
  input  logic gclk_lvl,
  input  logic clk_inv,
  output logic tick
);
  logic src_raw;
  logic src_eff;
  logic prev_eff;

  always_comb begin
    if (c_is_clk)      src_raw = sum_c;
    else if (d_is_clk) src_raw = sum_d;
    else               src_raw = gclk_lvl;
  end

  assign src_eff = src_raw ^ clk_inv;

  // Held high in reset so that a source already high at release is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_eff <= 1'b1;
    else        prev_eff <= src_eff;
  end

  assign tick = src_eff & ~prev_eff;

endmodule

// File: rtl/mfc_state.sv
module mfc_state
  import mfc_pkg::*;
#(
  parameter logic Q_INIT = 1'b0
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rst_hit,
  input  logic       pre_hit,
  input  mfc_rtype_e eff_type,
  input  logic       din_j,
  input  logic       din_k,
  output logic       q
);
  logic q_next;

  always_comb begin
    if (rst_hit)      q_next = 1'b0;
    else if (pre_hit) q_next = 1'b1;
    else if (tick)    q_next = mfc_next_q(eff_type, q, din_j, din_k);
    else              q_next = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= Q_INIT;
    else        q <= q_next;
  end

endmodule

// File: rtl/mfc_route.sv
module mfc_route
  import mfc_pkg::*;
(
  input  logic [MFC_SEL_W-1:0] sel,
  input  logic                 q,
  input  logic                 sum_a,
  input  logic                 sum_b,
  input  logic                 sum_c,
  output logic                 y
);
  always_comb begin
    case (sel)
      SEL_A:   y = sum_a;
      SEL_B:   y = sum_b;
      SEL_C:   y = sum_c;
      default: y = q;
    endcase
  end
endmodule

// File: rtl/mfc_cell.sv
module mfc_cell
  import mfc_pkg::*;
#(
  parameter logic Q_INIT = 1'b0
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sum_a,
  input  logic                  sum_b,
  input  logic                  sum_c,
  input  logic                  sum_d,
  input  logic                  gclk_lvl,
  input  logic                  g_preset,
  input  logic                  g_reset,
  input  logic                  g_rtype,
  input  logic                  cfg_a_role,
  input  logic [MFC_ROLE_W-1:0] cfg_b_role,
  input  logic [MFC_ROLE_W-1:0] cfg_c_role,
  input  logic [MFC_ROLE_W-1:0] cfg_d_role,
  input  logic [1:0]            cfg_type,
  input  logic                  cfg_rt_en,
  input  logic                  cfg_rt_alt,
  input  logic                  cfg_clk_inv,
  input  logic [MFC_SEL_W-1:0]  cfg_io_sel,
  input  logic [MFC_SEL_W-1:0]  cfg_fb_sel,
  output logic                  io_out,
  output logic                  io_oe,
  output logic                  fb_out,
  output logic                  bur_out
);
  // Named internal events, also observed by the bound checker.
  logic       tick;
  logic       rst_hit;
  logic       pre_hit;
  logic       din_j;
  logic       din_k;
  logic       q;
  mfc_rtype_e eff_type;
  logic [1:0] eff_type_bits;

  assign rst_hit       = ((cfg_c_role == C_RESET) & sum_c) | g_reset;
  assign pre_hit       = ((cfg_b_role == B_PRESET) & sum_b) | g_preset;
  assign din_j         = (cfg_a_role == A_DATA) & sum_a;
  assign din_k         = (cfg_b_role == B_K) & sum_b;
  assign eff_type      = mfc_eff_type(cfg_type, cfg_rt_en, cfg_rt_alt, g_rtype);
  assign eff_type_bits = eff_type;

  mfc_clk_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .c_is_clk (cfg_c_role == C_CLK),
    .d_is_clk (cfg_d_role == D_CLK),
    .sum_c    (sum_c),
    .sum_d    (sum_d),
    .gclk_lvl (gclk_lvl),
    .clk_inv  (cfg_clk_inv),
    .tick     (tick)
  );

  mfc_state #(.Q_INIT(Q_INIT)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rst_hit  (rst_hit),
    .pre_hit  (pre_hit),
    .eff_type (eff_type),
    .din_j    (din_j),
    .din_k    (din_k),
    .q        (q)
  );

  logic [MFC_SEL_W-1:0] route_sel [MFC_NROUTE];
  logic [MFC_NROUTE-1:0] route_y;

  assign route_sel[0] = cfg_io_sel;
  assign route_sel[1] = cfg_fb_sel;

  for (genvar g = 0; g < MFC_NROUTE; g++) begin : g_route
    mfc_route u_route (
      .sel   (route_sel[g]),
      .q     (q),
      .sum_a (sum_a),
      .sum_b (sum_b),
      .sum_c (sum_c),
      .y     (route_y[g])
    );
  end

  assign io_out  = route_y[0];
  assign fb_out  = route_y[1];
  assign io_oe   = (cfg_d_role == D_OE) ? sum_d : 1'b1;
  assign bur_out = (cfg_d_role == D_FB) & sum_d;

endmodule

// File: rtl/mfc_cell_chk.sv
module mfc_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       rst_hit,
  input logic       pre_hit,
  input logic       din_j,
  input logic       din_k,
  input logic       q,
  input logic [1:0] eff_type_bits
);
  logic quiet;
  assign quiet = !rst_hit && !pre_hit;

  p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> !q);

  p_preset_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_hit && !rst_hit) |=> q);

  p_hold_no_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !tick) |=> $stable(q));

  p_d_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && tick && eff_type_bits == 2'd0) |=> (q == $past(din_j)));

  p_t_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && tick && eff_type_bits == 2'd1 && din_j) |=> (q != $past(q)));

  p_jk_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && tick && eff_type_bits == 2'd2 && din_j && !din_k) |=> q);

  p_jk_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && tick && eff_type_bits == 2'd2 && !din_j && din_k) |=> !q);

endmodule

bind mfc_cell mfc_cell_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .rst_hit       (rst_hit),
  .pre_hit       (pre_hit),
  .din_j         (din_j),
  .din_k         (din_k),
  .q             (q),
  .eff_type_bits (eff_type_bits)
);

// File: tb/mfc_cell_bench.sv
module mfc_cell_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic sum_a, sum_b, sum_c, sum_d, gclk_lvl, g_preset, g_reset, g_rtype;
  logic cfg_a_role, cfg_rt_en, cfg_rt_alt, cfg_clk_inv;
  logic [1:0] cfg_b_role, cfg_c_role, cfg_d_role, cfg_type, cfg_io_sel, cfg_fb_sel;
  logic io_out, io_oe, fb_out, bur_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  mfc_cell u_mfc_cell (
    .clk(clk), .rst_n(rst_n), .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c),
    .sum_d(sum_d), .gclk_lvl(gclk_lvl), .g_preset(g_preset), .g_reset(g_reset),
    .g_rtype(g_rtype), .cfg_a_role(cfg_a_role), .cfg_b_role(cfg_b_role),
    .cfg_c_role(cfg_c_role), .cfg_d_role(cfg_d_role), .cfg_type(cfg_type),
    .cfg_rt_en(cfg_rt_en), .cfg_rt_alt(cfg_rt_alt), .cfg_clk_inv(cfg_clk_inv),
    .cfg_io_sel(cfg_io_sel), .cfg_fb_sel(cfg_fb_sel), .io_out(io_out),
    .io_oe(io_oe), .fb_out(fb_out), .bur_out(bur_out)
  );

  // 4-bit loadable counter: D mode loads, T mode counts (R8).
  logic       cnt_load;
  logic [3:0] cnt_val, cnt_a, cnt_q, cnt_io, cnt_oe, cnt_bur;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      cnt_a[i] = cnt_load ? cnt_val[i] : 1'b1;
      for (int k = 0; k < i; k++)
        if (!cnt_load && !cnt_q[k]) cnt_a[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_cnt
    mfc_cell u_cnt (
      .clk(clk), .rst_n(rst_n), .sum_a(cnt_a[i]), .sum_b(1'b0), .sum_c(1'b0),
      .sum_d(1'b0), .gclk_lvl(gclk_lvl), .g_preset(1'b0), .g_reset(1'b0),
      .g_rtype(!cnt_load), .cfg_a_role(1'b0), .cfg_b_role(2'd0),
      .cfg_c_role(2'd0), .cfg_d_role(2'd0), .cfg_type(2'd0), .cfg_rt_en(1'b1),
      .cfg_rt_alt(1'b0), .cfg_clk_inv(1'b0), .cfg_io_sel(2'd0),
      .cfg_fb_sel(2'd0), .io_out(cnt_io[i]), .io_oe(cnt_oe[i]),
      .fb_out(cnt_q[i]), .bur_out(cnt_bur[i])
    );
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse();
    gclk_lvl = 1'b0; step();
    gclk_lvl = 1'b1; step();
  endtask

  task automatic set_defaults();
    sum_a = 0; sum_b = 0; sum_c = 0; sum_d = 0; gclk_lvl = 0;
    g_preset = 0; g_reset = 0; g_rtype = 0;
    cfg_a_role = 0; cfg_b_role = 0; cfg_c_role = 0; cfg_d_role = 0;
    cfg_type = 0; cfg_rt_en = 0; cfg_rt_alt = 0; cfg_clk_inv = 0;
    cfg_io_sel = 0; cfg_fb_sel = 0;
  endtask

  task automatic do_reset();
    set_defaults();
    rst_n = 0; step(); step();
    rst_n = 1; step();
  endtask

  // Bench-side model of the requirements.
  function automatic logic ref_next(input logic [1:0] t, input logic q,
                                    input logic j, input logic k);
    if (t == 2'd1) return j ? !q : q;
    if (t == 2'd2) begin
      if (j && k) return !q;
      if (j)      return 1'b1;
      if (k)      return 1'b0;
      return q;
    end
    return j;
  endfunction

  function automatic logic ref_route(input logic [1:0] s, input logic q);
    case (s)
      2'd1: return sum_a;
      2'd2: return sum_b;
      2'd3: return sum_c;
      default: return q;
    endcase
  endfunction

  logic m_q, m_prev;

  task automatic rstep();
    logic src, eff, rs, ps, j, k;
    logic [1:0] t;
    src = (cfg_c_role == 2'd1) ? sum_c : (cfg_d_role == 2'd1) ? sum_d : gclk_lvl;
    eff = src ^ cfg_clk_inv;
    rs  = (cfg_c_role == 2'd2 && sum_c) || g_reset;
    ps  = (cfg_b_role == 2'd2 && sum_b) || g_preset;
    j   = (cfg_a_role == 1'b0) && sum_a;
    k   = (cfg_b_role == 2'd1) && sum_b;
    if (cfg_rt_en && g_rtype) t = cfg_rt_alt ? 2'd2 : 2'd1;
    else                      t = (cfg_type == 2'd3) ? 2'd0 : cfg_type;
    if (rs)                   m_q = 1'b0;
    else if (ps)              m_q = 1'b1;
    else if (eff && !m_prev)  m_q = ref_next(t, m_q, j, k);
    m_prev = eff;
    step();
    chk("R9 io_out random", {7'd0, io_out}, {7'd0, ref_route(cfg_io_sel, m_q)});
    chk("R2/R3/R4/R5 fb_out random", {7'd0, fb_out}, {7'd0, ref_route(cfg_fb_sel, m_q)});
    chk("R10 io_oe random", {7'd0, io_oe}, {7'd0, (cfg_d_role == 2'd2) ? sum_d : 1'b1});
    chk("R10 bur_out random", {7'd0, bur_out}, {7'd0, (cfg_d_role == 2'd0) && sum_d});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    cnt_load = 0; cnt_val = 0;
    set_defaults();
    rst_n = 0;
    repeat (3) step();
    chk("R1 in reset", {7'd0, fb_out}, 8'd0);
    rst_n = 1; step();
    chk("R1 after release", {7'd0, io_out}, 8'd0);

    // R2 D load and R5 hold without edge
    sum_a = 1; pulse();
    chk("R2 load 1", {7'd0, fb_out}, 8'd1);
    sum_a = 0; step(); step();
    chk("R5 no edge holds", {7'd0, fb_out}, 8'd1);
    pulse();
    chk("R2 load 0", {7'd0, fb_out}, 8'd0);

    // R5 inverted polarity
    do_reset();
    cfg_clk_inv = 1; step();
    sum_a = 1; gclk_lvl = 1; step();
    chk("R5 rising ignored when inverted", {7'd0, fb_out}, 8'd0);
    gclk_lvl = 0; step();
    chk("R5 falling edge loads", {7'd0, fb_out}, 8'd1);

    // R5 sum-term clock on C
    do_reset();
    cfg_c_role = 2'd1; sum_a = 1; pulse();
    chk("R5 global clock ignored", {7'd0, fb_out}, 8'd0);
    sum_c = 1; step();
    chk("R5 C clock loads", {7'd0, fb_out}, 8'd1);

    // R3 T mode
    do_reset();
    cfg_type = 2'd1; sum_a = 1; pulse();
    chk("R3 toggle up", {7'd0, fb_out}, 8'd1);
    pulse();
    chk("R3 toggle down", {7'd0, fb_out}, 8'd0);
    sum_a = 0; pulse();
    chk("R3 hold", {7'd0, fb_out}, 8'd0);

    // R4 JK mode
    do_reset();
    cfg_type = 2'd2; cfg_b_role = 2'd1;
    sum_a = 1; sum_b = 0; pulse(); chk("R4 set", {7'd0, fb_out}, 8'd1);
    sum_a = 0; sum_b = 0; pulse(); chk("R4 hold", {7'd0, fb_out}, 8'd1);
    sum_a = 1; sum_b = 1; pulse(); chk("R4 toggle down", {7'd0, fb_out}, 8'd0);
    pulse();                         chk("R4 toggle up", {7'd0, fb_out}, 8'd1);
    sum_a = 0; sum_b = 1; pulse(); chk("R4 clear", {7'd0, fb_out}, 8'd0);

    // R6 / R7 priorities
    do_reset();
    cfg_b_role = 2'd2; cfg_c_role = 2'd2;
    sum_b = 1; step(); chk("R7 B preset", {7'd0, fb_out}, 8'd1);
    sum_c = 1; step(); chk("R6 reset over preset", {7'd0, fb_out}, 8'd0);
    sum_b = 0; sum_c = 0; g_preset = 1; step();
    chk("R7 global preset", {7'd0, fb_out}, 8'd1);
    g_reset = 1; step(); chk("R6 global reset", {7'd0, fb_out}, 8'd0);
    g_preset = 0; g_reset = 0; sum_a = 1; sum_c = 1; pulse();
    chk("R6 reset over clock", {7'd0, fb_out}, 8'd0);
    sum_c = 0; sum_a = 0; sum_b = 1; pulse();
    chk("R7 preset over clock", {7'd0, fb_out}, 8'd1);
    sum_b = 0;

    // R8 run-time type switch
    do_reset();
    cfg_rt_en = 1; g_rtype = 1; sum_a = 1; pulse();
    chk("R8 switched T up", {7'd0, fb_out}, 8'd1);
    pulse(); chk("R8 switched T down", {7'd0, fb_out}, 8'd0);
    g_rtype = 0; pulse(); chk("R8 back to D", {7'd0, fb_out}, 8'd1);
    pulse(); chk("R8 D keeps 1", {7'd0, fb_out}, 8'd1);
    cfg_rt_en = 0; g_rtype = 1; pulse();
    chk("R8 switch ignored when disabled", {7'd0, fb_out}, 8'd1);
    g_rtype = 0;

    // R9 routing
    cfg_io_sel = 2'd1; cfg_fb_sel = 2'd3; sum_a = 1; sum_c = 0; step();
    chk("R9 io=A", {7'd0, io_out}, 8'd1);
    chk("R9 fb=C", {7'd0, fb_out}, 8'd0);
    sum_a = 0; sum_c = 1; step();
    chk("R9 io=A low", {7'd0, io_out}, 8'd0);
    chk("R9 fb=C high", {7'd0, fb_out}, 8'd1);
    cfg_io_sel = 2'd2; sum_b = 1; step();
    chk("R9 io=B", {7'd0, io_out}, 8'd1);

    // R10 enable and buried path
    set_defaults(); cfg_d_role = 2'd2; step();
    chk("R10 oe from D low", {7'd0, io_oe}, 8'd0);
    chk("R10 bur off in oe role", {7'd0, bur_out}, 8'd0);
    sum_d = 1; step();
    chk("R10 oe from D high", {7'd0, io_oe}, 8'd1);
    cfg_d_role = 2'd0; step();
    chk("R10 oe fixed on", {7'd0, io_oe}, 8'd1);
    chk("R10 bur follows D", {7'd0, bur_out}, 8'd1);

    // R11 combinational A does not feed the register
    do_reset();
    cfg_a_role = 1; g_preset = 1; step(); g_preset = 0;
    sum_a = 1; pulse();
    chk("R11 D loads 0 when A combinational", {7'd0, fb_out}, 8'd0);
    cfg_type = 2'd1; g_preset = 1; step(); g_preset = 0; pulse();
    chk("R11 T holds when A combinational", {7'd0, fb_out}, 8'd1);

    // R8 loadable counter across wrap
    do_reset();
    cnt_load = 1; cnt_val = 4'd13; pulse();
    chk("R8 counter load", {4'd0, cnt_q}, 8'd13);
    cnt_load = 0;
    for (int n = 1; n <= 20; n++) begin
      pulse();
      chk("R8 counter count", {4'd0, cnt_q}, {4'd0, 4'(13 + n)});
    end

    // Random phase
    void'($urandom(32'h5eed_1234));
    set_defaults(); rst_n = 0; step(); step();
    m_q = 0; m_prev = 1;
    rst_n = 1;
    for (int b = 0; b < 40; b++) begin
      cfg_a_role  = 1'($urandom_range(1));
      cfg_b_role  = 2'($urandom_range(2));
      cfg_c_role  = 2'($urandom_range(2));
      cfg_d_role  = 2'($urandom_range(2));
      cfg_type    = 2'($urandom_range(3));
      cfg_rt_en   = 1'($urandom_range(1));
      cfg_rt_alt  = 1'($urandom_range(1));
      cfg_clk_inv = 1'($urandom_range(1));
      cfg_io_sel  = 2'($urandom_range(3));
      cfg_fb_sel  = ($urandom_range(1) == 0) ? 2'd0 : 2'($urandom_range(3));
      for (int s = 0; s < 40; s++) begin
        sum_a    = 1'($urandom_range(1));
        sum_b    = ($urandom_range(3) == 0);
        sum_c    = 1'($urandom_range(1));
        sum_d    = 1'($urandom_range(1));
        gclk_lvl = 1'($urandom_range(1));
        g_rtype  = 1'($urandom_range(1));
        g_preset = ($urandom_range(15) == 0);
        g_reset  = ($urandom_range(15) == 0);
        rstep();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule